// File: doc/BRIEF.md
# Grouped Sub-Interrupt Controller

This block collects thirty-two peripheral interrupt sources into a status register, qualifies them with a mask register, and reduces the result onto three summary lines for a parent aggregator. The audio line covers sources 0 to 7, the miscellaneous line covers 8 to 15, and the serial/parallel line covers 16 to 31. The block also reports the lowest-numbered source that is both pending and unmasked, as an index with a valid flag. Service code uses that index to find which source to handle.

Most sources are level-sensitive, and their status bits follow the inputs. Sources 16, 22 and 28 are edge-latched. Each holds its status bit after the input falls, until software clears it by writing the status register with that bit at zero. Sources 10 and 12 are polled conditions. Their status bits can be read back, but they never raise a summary line or take part in the index. Reset leaves both registers at zero.

Top module: `grp_irq_sub`

## Requirements
- R1: While reset is held and after it is released, the status and mask read back as zero, and the summaries, index and valid flag are all zero until something is pending and unmasked.
- R2: Every status bit other than 16, 22 and 28 equals its source input sampled at the previous clock edge. A status write has no effect on these bits.
- R3: Status bits 16, 22 and 28 are set at a clock edge where the source is high and was low at the edge before. The bit then stays set after the input falls.
- R4: A status write (regAddr = 0) clears edge bit 16, 22 or 28 when the matching data bit is 0, and leaves it unchanged when the data bit is 1. A rising edge in the same cycle as a clear wins, so the bit stays set.
- R5: A mask write (regAddr = 1) loads all 32 mask bits. The read data is combinational: regAddr = 0 returns the status and regAddr = 1 returns the mask.
- R6: grpOut[0] (sources 0-7), grpOut[1] (8-15) and grpOut[2] (16-31) are each high when at least one source in that group has both its status bit and its mask bit at 1. Each line changes one clock after the status or mask bit that drives it.
- R7: Sources 10 and 12 never raise a summary line and are never reported as the index, although their status bits read back.
- R8: validOut is 1 and idxOut holds the lowest-numbered eligible source that is pending and unmasked. When none exists, validOut is 0 and idxOut is 0. Both are registered with the same one-clock timing as the summaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 32 | Raw source inputs, one per source |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 status, 1 mask (read and write) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register |
| grpOut | output | 3 | Summaries: bit 0 audio, bit 1 misc, bit 2 serial/parallel |
| idxOut | output | 5 | Lowest pending unmasked source |
| validOut | output | 1 | idxOut is meaningful |

## Verification
A source change or register write is captured at the next clock edge, so the status and mask read data is due one clock after the stimulus. The summaries, index and valid flag are due one clock after that. The bench drives inputs on the falling edge and updates its behavioural model at the rising edge from those same inputs. It compares every output a quarter period after each rising edge. The directed checks wait one `tick` before reading the registers and two before reading the reduced outputs.

// File: rtl/gsic_pkg.sv
package gsic_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } regSel_e;

  typedef struct packed {
    logic statusWr;
    logic maskWr;
  } regStrb_t;
endpackage

// File: rtl/gsic_ctrl.sv
module gsic_ctrl
  import gsic_pkg::*;
(
  input  logic     regWrEn,
  input  logic     regAddr,
  output regStrb_t strb
);
  regSel_e sel;

  always_comb begin
    sel = regSel_e'(regAddr);
    strb.statusWr = regWrEn && (sel == SEL_STATUS);
    strb.maskWr   = regWrEn && (sel == SEL_MASK);
  end
endmodule

// File: rtl/gsic_datapath.sv
module gsic_datapath
  import gsic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 32'h1041_0000,
  parameter logic [NUM_SRC-1:0] POLL_MASK = 32'h0000_1400
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  regStrb_t           strb,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               regAddr,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_SRC-1:0] pendOut
);
  logic [NUM_SRC-1:0] statusQ, maskQ, prevQ;
  logic [NUM_SRC-1:0] statusNext, keepBits, riseBits;
  logic armedQ;

  always_comb begin
    keepBits = statusQ & EDGE_MASK;
    if (strb.statusWr) keepBits = keepBits & wrData;
    riseBits   = srcIn & ~prevQ & EDGE_MASK;
    statusNext = (srcIn & ~EDGE_MASK) | keepBits | riseBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      prevQ   <= '0;
      armedQ  <= 1'b0;
    end else begin
      statusQ <= statusNext;
      prevQ   <= srcIn;
      armedQ  <= 1'b1;
      if (strb.maskWr) maskQ <= wrData;
    end
  end

  assign rdData  = regAddr ? maskQ : statusQ;
  assign pendOut = statusQ & maskQ & ~POLL_MASK;

  // R2
  level_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> (((statusQ ^ $past(srcIn)) & ~EDGE_MASK) == '0));

  // R3
  edge_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> ((statusQ & ~$past(statusQ) & EDGE_MASK & ~$past(srcIn)) == '0));

  // R4
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> (($past(statusQ) & ~statusQ & EDGE_MASK &
                 ~$past({NUM_SRC{strb.statusWr}} & ~wrData)) == '0));
endmodule

// File: rtl/gsic_reduce.sv
module gsic_reduce #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned AUD_END  = 8,
  parameter int unsigned MISC_END = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendIn,
  output logic [2:0]         grpOut,
  output logic [IDX_W-1:0]   idxOut,
  output logic               validOut
);
  logic [2:0]       grpNext;
  logic [IDX_W-1:0] idxNext;

  for (genvar g = 0; g < 3; g++) begin : gen_grp
    localparam int unsigned LO = (g == 0) ? 0 : (g == 1) ? AUD_END : MISC_END;
    localparam int unsigned HI = (g == 0) ? AUD_END : (g == 1) ? MISC_END : NUM_SRC;
    assign grpNext[g] = |pendIn[HI-1:LO];
  end

  always_comb begin
    idxNext = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendIn[i]) idxNext = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpOut   <= '0;
      idxOut   <= '0;
      validOut <= 1'b0;
    end else begin
      grpOut   <= grpNext;
      idxOut   <= idxNext;
      validOut <= |pendIn;
    end
  end

  // R8
  valid_summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut == (|grpOut));

  // R8
  idle_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> (idxOut == '0));

  // R6
  index_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> ((32'(idxOut) < AUD_END) ? grpOut[0] :
                  (32'(idxOut) < MISC_END) ? (grpOut[1] && !grpOut[0]) :
                  (grpOut[2] && (grpOut[1:0] == 2'b00))));
endmodule

// File: rtl/grp_irq_sub.sv
module grp_irq_sub
  import gsic_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned AUD_END  = 8,
  parameter int unsigned MISC_END = 16,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 32'h1041_0000,
  parameter logic [NUM_SRC-1:0] POLL_MASK = 32'h0000_1400,
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  output logic [2:0]         grpOut,
  output logic [IDX_W-1:0]   idxOut,
  output logic               validOut
);
  regStrb_t           strb;
  logic [NUM_SRC-1:0] pend;

  gsic_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gsic_datapath #(
    .NUM_SRC   (NUM_SRC),
    .EDGE_MASK (EDGE_MASK),
    .POLL_MASK (POLL_MASK)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .strb    (strb),
    .wrData  (regWrData),
    .regAddr (regAddr),
    .rdData  (regRdData),
    .pendOut (pend)
  );

  gsic_reduce #(
    .NUM_SRC  (NUM_SRC),
    .AUD_END  (AUD_END),
    .MISC_END (MISC_END)
  ) u_red (
    .clk      (clk),
    .rstN     (rstN),
    .pendIn   (pend),
    .grpOut   (grpOut),
    .idxOut   (idxOut),
    .validOut (validOut)
  );

  // R7
  poll_excluded_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> !POLL_MASK[idxOut]);
endmodule

// File: tb/grp_irq_sub_tb_top.sv
module grp_irq_sub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;
  localparam logic [31:0] EDGES = 32'h1041_0000;
  localparam logic [31:0] POLLS = 32'h0000_1400;

  logic clk = 0, rstN = 0;
  logic [31:0] srcIn = '0, regWrData = '0;
  logic regWrEn = 0, regAddr = 0;
  logic [31:0] regRdData;
  logic [2:0] grpOut;
  logic [4:0] idxOut;
  logic validOut;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  logic [31:0] mStatus = '0, mMask = '0, mPrev = '0;
  logic [2:0] mGrp = '0;
  int mIdx = 0;
  bit mValid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_irq_sub dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .grpOut(grpOut),
    .idxOut(idxOut), .validOut(validOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(logic addr, logic [31:0] data);
    regAddr = addr; regWrData = data; regWrEn = 1;
    tick();
    regWrEn = 0;
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    logic [31:0] pend, nxt;
    cycles++;
    if (!rstN) begin
      mStatus = '0; mMask = '0; mPrev = '0; mGrp = '0; mIdx = 0; mValid = 0;
    end else begin
      pend = mStatus & mMask & ~POLLS;
      mGrp = '0; mValid = 0; mIdx = 0;
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (pend[i]) begin
          mValid = 1; mIdx = i;
          if (i < 8) mGrp[0] = 1; else if (i < 16) mGrp[1] = 1; else mGrp[2] = 1;
        end
      end
      for (int i = 0; i < NSRC; i++) begin
        if (EDGES[i]) begin
          nxt[i] = mStatus[i];
          if (regWrEn && !regAddr && !regWrData[i]) nxt[i] = 0;
          if (srcIn[i] && !mPrev[i]) nxt[i] = 1;
        end else begin
          nxt[i] = srcIn[i];
        end
      end
      if (regWrEn && regAddr) mMask = regWrData;
      mStatus = nxt;
      mPrev = srcIn;
    end
  end

  // per-cycle comparison, away from both edges
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN && !done) begin
      check("R5 read data", regRdData, regAddr ? mMask : mStatus);
      check("R6 summaries", {29'd0, grpOut}, {29'd0, mGrp});
      check("R8 valid", {31'd0, validOut}, {31'd0, mValid});
      check("R8 index", {27'd0, idxOut}, 32'(mIdx));
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) tick();
    regAddr = 0; #1;
    check("R1 status", regRdData, 32'h0);
    regAddr = 1; #1;
    check("R1 mask", regRdData, 32'h0);
    check("R1 grp", {29'd0, grpOut}, 32'h0);
    check("R1 valid", {31'd0, validOut}, 32'h0);
    rstN = 1;
    tick();
    check("R1 after release", {29'd0, grpOut, validOut}, 32'h0);

    regWrite(1, 32'hFFFF_FFFF);
    regAddr = 1; #1;
    check("R5 mask readback", regRdData, 32'hFFFF_FFFF);
    regAddr = 0;

    srcIn = (32'h1 << 3) | (32'h1 << 9);
    tick(); #1;
    check("R2 level status", regRdData, 32'h0000_0208);
    check("R6 not yet", {29'd0, grpOut}, 32'h0);
    tick();
    check("R6 audio+misc", {29'd0, grpOut}, 32'h3);
    check("R8 lowest", {27'd0, idxOut}, 32'd3);

    srcIn = (32'h1 << 9) | POLLS;
    tick(); tick();
    check("R7 misc from 9", {29'd0, grpOut}, 32'h2);
    check("R8 idx 9", {27'd0, idxOut}, 32'd9);

    srcIn = POLLS;
    tick(); tick(); #1;
    check("R7 poll status reads", regRdData, POLLS);
    check("R7 no summary", {29'd0, grpOut}, 32'h0);
    check("R7 no valid", {31'd0, validOut}, 32'h0);

    srcIn = '0;
    tick();
    regWrite(0, 32'hFFFF_FFFF);
    #1;
    check("R2 write ignored", regRdData, 32'h0);

    srcIn = 32'h1 << 22;
    tick();
    srcIn = '0;
    tick(); #1;
    check("R3 edge held", regRdData, 32'h0040_0000);
    check("R8 idx 22", {27'd0, idxOut}, 32'd22);
    check("R6 serial", {29'd0, grpOut}, 32'h4);
    regWrite(0, 32'hFFFF_FFFF);
    #1;
    check("R4 ones keep", regRdData, 32'h0040_0000);
    regWrite(0, ~(32'h1 << 22));
    #1;
    check("R4 cleared", regRdData, 32'h0);

    srcIn = 32'h1 << 28;
    regWrite(0, 32'h0);
    #1;
    check("R4 set wins", regRdData, 32'h1000_0000);
    srcIn = '0;
    regWrite(0, 32'h0);

    regWrite(1, 32'h0000_FF00);
    srcIn = 32'h1 << 3;
    tick(); tick();
    check("R6 masked audio", {29'd0, grpOut}, 32'h0);
    check("R8 masked valid", {31'd0, validOut}, 32'h0);

    // random phase, model compared every clock
    for (int n = 0; n < 4000; n++) begin
      srcIn = $urandom() & $urandom();
      regWrEn = (($urandom() % 8) == 0);
      regAddr = $urandom() % 2;
      regWrData = $urandom() | $urandom();
      tick();
    end
    regWrEn = 0;
    tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule